// File: doc/BRIEF.md
# Ramp-Compare PWM with Startup Gating

This block produces a pulse-width-modulated output from an 8-bit duty level. A free-running ramp counts down from its top value to zero and then reloads, which gives a period of 256 clocks at the default width. A registered comparator drives the output high while the captured duty level is greater than the ramp. The duty level is sampled only when the ramp reloads, so the level applied in a period stays constant for the whole period. A one-clock `period_start_o` strobe marks each reload.

An active-high `halt` input synchronously holds the ramp, the comparator, the startup counter and the output filter in their reset state. When `halt` falls, the ramp steps from its reset value of zero to the top value on the first clock. A startup counter keeps the output forced low for a programmable number of clocks, 193 by default, so that a slow upstream source has time to settle. The gated comparator result then passes through a two-flop filter. Because that filter is cleared together with the rest of the block, a restart cannot produce a stray pulse. Everything runs on one clock.

Top module: `pwm_ramp_cmp`

## Requirements
- R1: `period_start_o` is high for exactly one clock every 256 clocks. The first strobe is seen in the first cycle after the first clock edge with `halt` low.
- R2: `duty_i` is sampled only on the clock edge that raises `period_start_o`. A change of `duty_i` at any other time has no effect on the output until the next strobe.
- R3: In steady state, every 256-clock window contains exactly `duty` high cycles of `pwm_o`. A duty of 0 keeps the output low, a duty of 255 gives 255 high cycles, and a duty of 1 gives one high cycle.
- R4: Take the cycle s in which `period_start_o` is high, with duty d captured at that strobe. `pwm_o` is high in cycles s+259-d through s+258. With d = 255, the output is low in cycle s+3 and high in cycle s+4.
- R5: After a clock edge with `halt` high, `pwm_o` and `period_start_o` are both low, and they stay low while `halt` remains high.
- R6: After `halt` falls, `pwm_o` stays low for the first STARTUP_CLKS+1 cycles, whatever the duty.
- R7: The output path is the gated comparator result delayed by two flops, and both flops are cleared by `halt`. A pulse that was in flight when `halt` rose never appears after it.
- R8: Releasing `halt` again after a run repeats the same startup: the output is held low and then steady-state operation resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| halt | input | 1 | Active-high synchronous off/reset |
| duty_i | input | LEVEL_W | Duty level, sampled at each ramp reload |
| pwm_o | output | 1 | PWM output |
| period_start_o | output | 1 | One-clock strobe in the cycle the ramp holds its top value |

## Verification
The hardest situation to reach is a restart: `halt` is raised while the output is in the middle of a high stretch, then released with a duty that would drive the output high at once. That is the only case in which the startup gate and the cleared filter flops together decide the output. The bench reaches it by running at full duty until it is in steady state, pulsing `halt` for a single clock, and then counting the output over the startup window. The exact phase at which each pulse starts is checked by aligning to the strobe at full duty, where the single low cycle of each period is at a known place.

// File: rtl/pwm_rc_pkg.sv
// Package: shared defaults and the gate state type for the ramp-compare PWM.
// Assumes: nothing; it holds constants and types only.
package pwm_rc_pkg;
    localparam int unsigned LEVEL_W_DEF = 8;    // duty and ramp width
    localparam int unsigned STARTUP_DEF = 193;  // clocks the output is held low
    localparam int unsigned FILT_DEF    = 2;    // output filter depth

    typedef enum logic {
        GATE_WAIT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;
endpackage

// File: rtl/pwm_ramp.sv
// Module: down-counting ramp with a reload strobe.
// Resets to zero, so the first running clock loads the top value and raises the strobe.
// Assumes: halt is synchronous and active high.
module pwm_ramp #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         halt,
    output logic [W-1:0] ramp_o,
    output logic         reload_o,
    output logic         strobe_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] ramp_q;
    logic         strobe_q;

    // reload happens on the edge that follows a zero ramp value
    assign reload_o = (ramp_q == '0);

    // step the ramp down, wrap to the top value, and flag the wrap
    always_ff @(posedge clk) begin
        if (halt) begin
            ramp_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= reload_o;
            ramp_q   <= reload_o ? TOP : ramp_q - 1'b1;
        end
    end

    assign ramp_o   = ramp_q;
    assign strobe_o = strobe_q;

    assert_strobe_at_top_R1: assert property (@(posedge clk) disable iff (halt)
        strobe_q |-> (ramp_q == TOP));

    assert_ramp_step_R1: assert property (@(posedge clk) disable iff (halt)
        (ramp_q != '0) |=> (ramp_q == $past(ramp_q) - 1'b1));
endmodule

// File: rtl/pwm_duty_cmp.sv
// Module: duty capture and registered comparator.
// The duty level is latched only on a ramp reload. The compare result is registered,
// so it lags the ramp by one clock.
// Assumes: load_i is high in the cycle before the ramp takes its top value.
module pwm_duty_cmp #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         halt,
    input  logic         load_i,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] ramp_i,
    output logic         cmp_o
);
    logic [W-1:0] duty_q;
    logic         cmp_q;

    // hold the duty level for one full ramp period
    always_ff @(posedge clk) begin
        if (halt) begin
            duty_q <= '0;
        end else if (load_i) begin
            duty_q <= duty_i;
        end
    end

    // register the greater-than comparison against the ramp
    always_ff @(posedge clk) begin
        if (halt) begin
            cmp_q <= 1'b0;
        end else begin
            cmp_q <= (duty_q > ramp_i);
        end
    end

    assign cmp_o = cmp_q;

    assert_duty_hold_R2: assert property (@(posedge clk) disable iff (halt)
        !load_i |=> $stable(duty_q));

    assert_zero_duty_low_R3: assert property (@(posedge clk) disable iff (halt)
        (duty_q == '0) |=> !cmp_q);
endmodule

// File: rtl/pwm_start_gate.sv
// Module: startup delay that opens the output gate after CLKS running clocks.
// A zero CLKS opens the gate straight out of reset.
// Assumes: halt is synchronous and reloads the count.
module pwm_start_gate
    import pwm_rc_pkg::*;
#(
    parameter int unsigned CLKS = 193
) (
    input  logic clk,
    input  logic halt,
    output logic open_o
);
    localparam int unsigned CW = (CLKS < 1) ? 1 : $clog2(CLKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(CLKS);
    localparam gate_state_e INIT = (CLKS == 0) ? GATE_OPEN : GATE_WAIT;

    logic [CW-1:0] cnt_q;
    gate_state_e   state_q;

    // count down the startup window and open the gate on the last step
    always_ff @(posedge clk) begin
        if (halt) begin
            cnt_q   <= LOAD;
            state_q <= INIT;
        end else if (state_q == GATE_WAIT) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                state_q <= GATE_OPEN;
            end
        end
    end

    assign open_o = (state_q == GATE_OPEN);

    assert_open_after_count_R6: assert property (@(posedge clk) disable iff (halt)
        (state_q == GATE_OPEN) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_glitch_filter.sv
// Module: gated flop chain on the PWM path.
// Stage zero takes the compare result only while the gate is open. Every stage clears on halt.
// Assumes: STAGES is at least one.
module pwm_glitch_filter #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic halt,
    input  logic gate_i,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] stg_q;

    // first stage: masked compare result
    always_ff @(posedge clk) begin
        if (halt) begin
            stg_q[0] <= 1'b0;
        end else begin
            stg_q[0] <= gate_i & din_i;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // later stages: plain shift
        always_ff @(posedge clk) begin
            if (halt) begin
                stg_q[i] <= 1'b0;
            end else begin
                stg_q[i] <= stg_q[i-1];
            end
        end

        assert_shift_high_R7: assert property (@(posedge clk) disable iff (halt)
            stg_q[i-1] |=> stg_q[i]);
        assert_shift_low_R7: assert property (@(posedge clk) disable iff (halt)
            !stg_q[i-1] |=> !stg_q[i]);
    end

    assign dout_o = stg_q[STAGES-1];

    assert_closed_blocks_R6: assert property (@(posedge clk) disable iff (halt)
        !gate_i |=> !stg_q[0]);
endmodule

// File: rtl/pwm_ramp_cmp.sv
// Module: top of the ramp-compare PWM.
// Chains the ramp, the duty capture and compare, the startup gate and the output filter.
// Assumes: a single clock; halt is synchronous and active high.
module pwm_ramp_cmp
    import pwm_rc_pkg::*;
#(
    parameter int unsigned LEVEL_W      = LEVEL_W_DEF,
    parameter int unsigned STARTUP_CLKS = STARTUP_DEF,
    parameter int unsigned FILT_STAGES  = FILT_DEF
) (
    input  logic               clk,
    input  logic               halt,
    input  logic [LEVEL_W-1:0] duty_i,
    output logic               pwm_o,
    output logic               period_start_o
);
    logic [LEVEL_W-1:0] ramp;
    logic               reload;
    logic               cmp;
    logic               gate_open;

    pwm_ramp #(.W(LEVEL_W)) u_ramp (
        .clk      (clk),
        .halt     (halt),
        .ramp_o   (ramp),
        .reload_o (reload),
        .strobe_o (period_start_o)
    );

    pwm_duty_cmp #(.W(LEVEL_W)) u_cmp (
        .clk    (clk),
        .halt   (halt),
        .load_i (reload),
        .duty_i (duty_i),
        .ramp_i (ramp),
        .cmp_o  (cmp)
    );

    pwm_start_gate #(.CLKS(STARTUP_CLKS)) u_gate (
        .clk    (clk),
        .halt   (halt),
        .open_o (gate_open)
    );

    pwm_glitch_filter #(.STAGES(FILT_STAGES)) u_filt (
        .clk    (clk),
        .halt   (halt),
        .gate_i (gate_open),
        .din_i  (cmp),
        .dout_o (pwm_o)
    );
endmodule

// File: tb/sim_pwm_ramp_cmp.sv
// Bench: a behavioural model built from the requirements, compared on every falling edge.
module sim_pwm_ramp_cmp;
    localparam int D = 7;

    logic       clk = 1'b0;
    logic       halt = 1'b1;
    logic [7:0] duty = 8'd0;
    logic       pwm;
    logic       strobe;

    always #10 clk = ~clk;

    pwm_ramp_cmp #(.LEVEL_W(8), .STARTUP_CLKS(D), .FILT_STAGES(2)) u0 (
        .clk            (clk),
        .halt           (halt),
        .duty_i         (duty),
        .pwm_o          (pwm),
        .period_start_o (strobe)
    );

    int    n = 0;          // running edges since halt fell
    int    samp[int];      // duty captured per period index
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R5";

    // model: count running edges, record the duty seen at each reload edge
    always @(posedge clk) begin
        cyc++;
        if (halt) begin
            n = 0;
        end else begin
            n++;
            if (((n - 1) % 256) == 0) samp[(n - 1) / 256] = int'(duty);
        end
    end

    function automatic bit exp_pwm(int nn);
        int k;
        int r;
        int idx;
        k = nn - 3;
        if (nn < D + 2 || k < 1) return 1'b0;
        r   = 255 - ((k - 1) % 256);
        idx = (k - 1) / 256;
        if (!samp.exists(idx)) return 1'b0;
        return samp[idx] > r;
    endfunction

    function automatic bit exp_strobe(int nn);
        return (nn >= 1) && (((nn - 1) % 256) == 0);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(pwm === exp_pwm(n), tag, int'(pwm), int'(exp_pwm(n)));
            check(strobe === exp_strobe(n), "R1", int'(strobe), int'(exp_strobe(n)));
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0 (run did not end)", cyc);
            finish_run();
        end
    end

    task automatic run(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic count_high(int len, output int cnt);
        cnt = 0;
        repeat (len) begin
            @(negedge clk);
            cnt += int'(pwm);
        end
    endtask

    initial begin
        int cnt;
        halt = 1'b1;
        duty = 8'd128;
        run(3);
        chk_en = 1'b1;
        tag = "R5";
        run(3);
        check(pwm == 1'b0 && strobe == 1'b0, "R5", int'(pwm) + int'(strobe), 0);

        // R6: startup window, then steady operation
        tag = "R6";
        halt = 1'b0;
        run(D + 4);
        tag = "R3";
        run(600);

        // R2: mid-period duty changes only act at the next reload
        tag = "R2";
        duty = 8'd40;
        run(100);
        duty = 8'd200;
        run(700);

        // R3: exact high counts
        tag = "R3";
        duty = 8'd64;
        run(600);
        count_high(256, cnt);
        check(cnt == 64, "R3", cnt, 64);
        duty = 8'd0;
        run(600);
        count_high(256, cnt);
        check(cnt == 0, "R3", cnt, 0);
        duty = 8'd1;
        run(600);
        count_high(256, cnt);
        check(cnt == 1, "R3", cnt, 1);

        // R4: pulse phase relative to the strobe at full duty
        tag = "R4";
        duty = 8'd255;
        run(600);
        do @(negedge clk); while (!strobe);
        run(3);
        check(pwm == 1'b0, "R4", int'(pwm), 0);
        run(1);
        check(pwm == 1'b1, "R4", int'(pwm), 1);
        run(50);

        // R7: one-clock halt while the output is high
        tag = "R7";
        check(pwm == 1'b1, "R7", int'(pwm), 1);
        halt = 1'b1;
        run(1);
        check(pwm == 1'b0 && strobe == 1'b0, "R7", int'(pwm) + int'(strobe), 0);

        // R8: restart holds the output low, then resumes
        tag = "R8";
        halt = 1'b0;
        count_high(D + 1, cnt);
        check(cnt == 0, "R8", cnt, 0);
        run(300);
        count_high(256, cnt);
        check(cnt == 255, "R8", cnt, 255);

        finish_run();
    end
endmodule